// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Bit Slip

This block turns a serial bit stream, one bit per clock, into parallel words of `WORD_W` bits (four by default). A select pin picks which of two serial inputs feeds the shift register. The oldest bit of each word is placed in bit 0 of the output, and the newest is placed in the top bit. A free-running divider tracks where each word begins and ends. It also produces two single-cycle strobes: one every `WORD_W` clocks and one every `2*WORD_W` clocks. The serial stream leaves through a pass-through output so that a second converter can be chained behind the first.

The word boundary is moved with a slip input, which may be driven from any clock domain. A slip pulse is synchronised and edge-detected inside the block. Each pulse makes the divider skip exactly one count, so the boundary moves one bit later. A bit that would have landed on output bit n therefore lands on bit n-1, and bit 0 wraps to the top bit. To shift by several bits, apply several separate pulses. A wide-span mode stretches the update period from `WORD_W` to `2*WORD_W` clocks, which lets two instances form a double-width converter. Reset is active high and synchronous. It puts every divider and flop into a known phase, so that several instances start aligned.

The data interface is a stream without back-pressure. The bit rate sets the pace, so there is no ready. `word_valid_o` is high for the single cycle after each new word is loaded. The word then holds until the next load, so a consumer may take it at any point during the period.

Top module: `s2p_converter`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `word_o` is 0, `word_valid_o` is 0, both strobes are 0 and `ser_o` is 0.
- R2: When a word is loaded, the bit sampled earliest of its four appears on `word_o[0]` and the latest on `word_o[3]`. Example: the sequence 1,0,0,0 loads 4'b0001.
- R3: Counting rising edges after reset from 0, `div4_stb_o` is high in exactly the cycles where the divider count modulo 4 is 3. That is the cycle before edges 3, 7, 11 and so on, unless a slip intervenes.
- R4: `div8_stb_o` is high in exactly the cycles where the divider count modulo 8 is 7. It is never high without `div4_stb_o`.
- R5: With `mode_wide_i` = 0, the word loads on every edge that ends a `div4_stb_o` cycle. With `mode_wide_i` = 1, it loads only on edges that end a `div8_stb_o` cycle. `word_valid_o` is 1 for exactly the one cycle after each load.
- R6: A slip pulse held high for at least 2 clocks makes the divider keep its count on one edge. That edge is the third rising edge counted from the first edge that samples the pulse high. From then on, a bit that would have landed on output bit n lands on bit n-1, with bit 0 wrapping to bit 3.
- R7: One slip pulse of any length causes exactly one skipped count. Two separate pulses cause two.
- R8: With `sel_b_i` = 0, bits come from `din_a_i`. With `sel_b_i` = 1, bits come from `din_b_i`.
- R9: The bit sampled at edge k is driven on `ser_o` from edge k+3 until edge k+4.
- R10: Between loads, `word_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| din_a_i | input | 1 | Serial data input A |
| din_b_i | input | 1 | Serial data input B |
| sel_b_i | input | 1 | 1 selects input B, 0 selects input A |
| mode_wide_i | input | 1 | 1 updates the word every 2*WORD_W clocks, 0 every WORD_W clocks |
| slip_i | input | 1 | Asynchronous slip request, at least 2 clocks wide |
| word_o | output | WORD_W | Parallel word, oldest bit in bit 0 |
| word_valid_o | output | 1 | High for one cycle after each new word |
| div4_stb_o | output | 1 | One-cycle strobe at the end of each WORD_W period |
| div8_stb_o | output | 1 | One-cycle strobe at the end of each 2*WORD_W period |
| ser_o | output | 1 | Serial pass-through for chaining |

## Verification
The bench concentrates on the slip behaviour, because that is where a design fails quietly. It checks a single pulse, a pulse held for ten clocks, and two pulses in a row. A design that treats the slip as a level rather than an edge keeps rotating the word while the pin is high. A design that counts past the skipped edge leaves the boundary where it was. The bench also tests the wide-span mode, where a design that loads on the wrong strobe updates twice as often. It checks the word bit order, where a reversed shifter places the first bit in bit 3. It checks the pass-through delay, where an off-by-one register chain shifts the cascade stream by a bit.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

  typedef enum logic {
    SPAN_SINGLE = 1'b0,
    SPAN_DOUBLE = 1'b1
  } span_e;

  // width of a counter that spans two words
  function automatic int unsigned span_cnt_bits(input int unsigned word_w);
    return $clog2(2 * word_w);
  endfunction

endpackage

// File: rtl/s2p_slip_detect.sv
module s2p_slip_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic slip_i,
  output logic pulse_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= slip_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], slip_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) last_q <= 1'b0;
    else       last_q <= chain_q[STAGES-1];
  end

  assign pulse_o = chain_q[STAGES-1] & ~last_q;

  // R7: one request yields a pulse of a single cycle
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o)
    else $error("slip pulse longer than one cycle");

endmodule

// File: rtl/s2p_divider.sv
module s2p_divider #(
  parameter int unsigned WORD_W = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic stb_word_o,
  output logic stb_pair_o
);

  localparam int unsigned CNT_W = s2p_pkg::span_cnt_bits(WORD_W);
  localparam int unsigned LOW_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        cnt_q <= '0;
    else if (!hold_i) cnt_q <= cnt_q + ONE;
  end

  assign stb_word_o = &cnt_q[LOW_W-1:0];
  assign stb_pair_o = &cnt_q;

  // R3: without a skipped count the word strobe never lasts two cycles
  p_word_stb_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_word_o && !hold_i) |=> !stb_word_o)
    else $error("word strobe repeated");

  // R4: the long-period strobe is a subset of the short one
  p_pair_in_word_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_pair_o |-> stb_word_o)
    else $error("pair strobe without word strobe");

endmodule

// File: rtl/s2p_shifter.sv
module s2p_shifter #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              din_a_i,
  input  logic              din_b_i,
  input  logic              sel_b_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ser_o
);

  logic              bit_in;
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_next;
  logic [WORD_W-1:0] word_q;

  assign bit_in  = sel_b_i ? din_b_i : din_a_i;
  assign sr_next = {bit_in, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i) begin
    if (rst_i) sr_q <= '0;
    else       sr_q <= sr_next;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       word_q <= '0;
    else if (load_i) word_q <= sr_next;
  end

  assign word_o = word_q;
  assign ser_o  = sr_q[0];

  // R9: the pass-through lags the register input by WORD_W-1 edges;
  // checked for the newest bit reaching the next stage one edge later
  p_shift_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (sr_q[WORD_W-2] == $past(sr_q[WORD_W-1])))
    else $error("shift chain broken");

endmodule

// File: rtl/s2p_converter.sv
module s2p_converter #(
  parameter int unsigned WORD_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              din_a_i,
  input  logic              din_b_i,
  input  logic              sel_b_i,
  input  logic              mode_wide_i,
  input  logic              slip_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              div4_stb_o,
  output logic              div8_stb_o,
  output logic              ser_o
);

  import s2p_pkg::*;

  span_e span;
  logic  slip_pulse;
  logic  stb_word;
  logic  stb_pair;
  logic  load;
  logic  valid_q;

  assign span = span_e'(mode_wide_i);

  s2p_slip_detect #(.STAGES(SYNC_STAGES)) u_slip (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .slip_i  (slip_i),
    .pulse_o (slip_pulse)
  );

  s2p_divider #(.WORD_W(WORD_W)) u_div (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hold_i     (slip_pulse),
    .stb_word_o (stb_word),
    .stb_pair_o (stb_pair)
  );

  assign load = (span == SPAN_DOUBLE) ? stb_pair : stb_word;

  s2p_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .din_a_i (din_a_i),
    .din_b_i (din_b_i),
    .sel_b_i (sel_b_i),
    .load_i  (load),
    .word_o  (word_o),
    .ser_o   (ser_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) valid_q <= 1'b0;
    else       valid_q <= load;
  end

  assign word_valid_o = valid_q;
  assign div4_stb_o   = stb_word;
  assign div8_stb_o   = stb_pair;

  // R1: reset clears the word and its qualifier
  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (word_o == '0 && !word_valid_o))
    else $error("reset did not clear outputs");

  // R5: narrow span loads on every short strobe
  p_narrow_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_wide_i && div4_stb_o) |=> word_valid_o)
    else $error("narrow span missed a load");

  // R5: wide span ignores short strobes that are not long strobes
  p_wide_skip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_wide_i && !div8_stb_o) |=> !word_valid_o)
    else $error("wide span loaded early");

  // R10: no qualifier, no change
  p_word_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !word_valid_o |-> $stable(word_o))
    else $error("word changed without a load");

endmodule

// File: tb/tb_s2p_converter.sv
`timescale 1ns/1ps
module tb_s2p_converter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din_a = 1'b0, din_b = 1'b0, sel_b = 1'b0, mode_wide = 1'b0, slip = 1'b0;
  logic [3:0] word;
  logic       word_valid, div4_stb, div8_stb, ser;

  int checks = 0;
  int fails  = 0;

  // reference state derived from the requirements
  int         mc;
  int         cyc;
  int         swallow_at;
  logic       slip_prev;
  logic [3:0] hist;
  logic [3:0] exp_word;
  logic       exp_valid;
  logic       exp_ser;

  always #4 clk = ~clk;

  s2p_converter dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .din_a_i      (din_a),
    .din_b_i      (din_b),
    .sel_b_i      (sel_b),
    .mode_wide_i  (mode_wide),
    .slip_i       (slip),
    .word_o       (word),
    .word_valid_o (word_valid),
    .div4_stb_o   (div4_stb),
    .div8_stb_o   (div8_stb),
    .ser_o        (ser)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R1: reset state
  task automatic do_reset();
    rst  = 1'b1;
    slip = 1'b0;
    repeat (3) @(negedge clk);
    chk(word == 4'd0,  "R1 word",  word, 0);
    chk(!word_valid,   "R1 valid", word_valid, 0);
    chk(!div4_stb,     "R1 div4",  div4_stb, 0);
    chk(!div8_stb,     "R1 div8",  div8_stb, 0);
    chk(!ser,          "R1 ser",   ser, 0);
    rst = 1'b0;
    mc = 0; cyc = 0; swallow_at = -1; slip_prev = 1'b0;
    hist = '0; exp_word = '0; exp_valid = 1'b0; exp_ser = 1'b0;
  endtask

  // one bit time: check at negedge, drive, advance the reference, wait
  task automatic step(input logic a, input logic b, input logic s);
    logic       bit_in;
    logic       ld;
    logic [3:0] nh;
    chk(div4_stb == ((mc % 4) == 3), "R3 div4 strobe", div4_stb, ((mc % 4) == 3));
    chk(div8_stb == (mc == 7),       "R4 div8 strobe", div8_stb, (mc == 7));
    chk(word == exp_word,            "R2 R10 word",    word, exp_word);
    chk(word_valid == exp_valid,     "R5 valid",       word_valid, exp_valid);
    chk(ser == exp_ser,              "R9 serial out",  ser, exp_ser);
    din_a = a; din_b = b; slip = s;
    bit_in = sel_b ? b : a;
    if (s && !slip_prev) swallow_at = cyc + 2;   // R6 timing
    slip_prev = s;
    ld = mode_wide ? (mc == 7) : ((mc % 4) == 3);
    nh = {bit_in, hist[3:1]};
    if (ld) exp_word = nh;
    exp_valid = ld;
    exp_ser   = nh[0];
    hist      = nh;
    if (cyc != swallow_at) mc = (mc + 1) % 8;
    cyc++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    step(1'b0, 1'b0, 1'b0);
    chk(word == 4'd0 && !word_valid, "R1 after release", word, 0);
  endtask

  task automatic t_bit_order();
    mode_wide = 1'b0; sel_b = 1'b0;
    do_reset();
    step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
    chk(word == 4'b0001, "R2 first bit on bit0", word, 4'b0001);
    step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    chk(word == 4'b1100, "R2 last bits on top", word, 4'b1100);
  endtask

  task automatic t_narrow_random();
    mode_wide = 1'b0; sel_b = 1'b0;
    do_reset();
    for (int i = 0; i < 64; i++) step(1'($urandom), 1'($urandom), 1'b0);
  endtask

  task automatic t_select();
    logic [3:0] w;
    mode_wide = 1'b0; sel_b = 1'b1;
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
    chk(word == 4'b1111, "R8 input B", word, 4'b1111);
    for (int i = 0; i < 32; i++) begin
      w = 4'($urandom);
      step(w[0], w[1], 1'b0);
    end
    sel_b = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
    chk(word == 4'b0000, "R8 input A", word, 4'b0000);
  endtask

  task automatic t_wide();
    int loads;
    mode_wide = 1'b1; sel_b = 1'b0;
    do_reset();
    loads = 0;
    for (int i = 0; i < 64; i++) begin
      step(1'($urandom), 1'b0, 1'b0);
      if (word_valid) loads++;
    end
    chk(loads == 8, "R5 wide span load count", loads, 8);
  endtask

  // marker bit on every fourth position
  task automatic marker_run(input int n, input int slip_from, input int slip_len);
    for (int i = 0; i < n; i++)
      step((i % 4) == 0, 1'b0, (i >= slip_from) && (i < slip_from + slip_len));
  endtask

  task automatic t_slip_single();
    mode_wide = 1'b0; sel_b = 1'b0;
    do_reset();
    marker_run(12, 100, 0);
    chk(word == 4'b0001, "R6 before slip", word, 4'b0001);
    do_reset();
    marker_run(24, 5, 2);
    chk(word == 4'b1000, "R6 slipped one bit", word, 4'b1000);
  endtask

  task automatic t_slip_multi();
    mode_wide = 1'b0; sel_b = 1'b0;
    do_reset();
    marker_run(32, 5, 10);
    chk(word == 4'b1000, "R7 long pulse one slip", word, 4'b1000);
    do_reset();
    for (int i = 0; i < 40; i++)
      step((i % 4) == 0, 1'b0, (i >= 5 && i < 7) || (i >= 15 && i < 18));
    chk(word == 4'b0100, "R7 two pulses two slips", word, 4'b0100);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_bit_order();
    t_narrow_random();
    t_select();
    t_wide();
    t_slip_single();
    t_slip_multi();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule